// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block receives a payload byte stream for one channel and places it into host buffers that a ring of descriptors in memory points to. Each descriptor is 64 bits wide: bits [15:0] hold a status word, bits [31:16] a data-length field and bits [63:32] the buffer address. The block reads the current descriptor and checks that the host has handed it over. It then writes incoming bytes into that buffer. When the buffer closes, it writes the descriptor back and moves to the next one.

A buffer closes when it fills to a programmable maximum length or when the byte that ends a frame arrives. On the writeback the block marks the buffers that start and end a frame, and puts the total frame length into the last one. It returns ownership to the host unless the descriptor asks to stay with the engine. A per-descriptor request bit raises a buffer event. The block counts these events and raises an interrupt once the count reaches a programmable threshold. The host clears the interrupt and the count with a one-cycle pulse.

The descriptor port reads by ring index, and read data is valid in the cycle after the read strobe. Status bits: 15 empty (engine owns), 13 wrap, 12 event request, 11 last-in-frame, 10 first-in-frame, 9 continuous.

Top module: `rxring_top`

## Requirements
- R1: In the cycle after a descriptor read, the block looks at status bit 15. If it is 0, the block accepts no payload and reads the same index again two cycles after the previous read. It keeps doing this until the bit reads 1.
- R2: While it fills an owned descriptor, `inReady` is high. Each accepted byte is written in the same cycle to the buffer address plus the number of bytes already in this buffer.
- R3: A buffer closes on the accepted byte that carries `inEof`, or on the byte that brings its count to `maxLen`. The descriptor is written back in the next cycle, and the next read follows one cycle after that.
- R4: In normal mode (status bit 9 clear), the writeback clears status bit 15. The buffer address and all other host bits are kept.
- R5: In continuous mode (status bit 9 set), the writeback leaves status bit 15 set. The engine refills that descriptor on its next pass with no host action.
- R6: After a writeback, the index goes to 0 if status bit 13 was set, and otherwise goes up by one. The index is 13 bits wide, so the ring never spans more than 64 KB of descriptors.
- R7: The writeback sets bit 10 if the buffer's first byte carried `inSof`, and bit 11 if the buffer ended the frame. The length field holds the total frame length on the last buffer and the buffer's byte count on the others.
- R8: `bufEvent` pulses in the writeback cycle exactly when status bit 12 of that descriptor is set.
- R9: `irq` rises in the cycle after the event that brings the event count to at least `evtThreshold`, and then stays high. A pulse on `intClr` clears both `irq` and the count from the next cycle, and wins over an event in the same cycle.
- R10: While reset is asserted, `irq`, `inReady`, `bdWe`, `bufWe` and `bufEvent` are low and the index is 0. The first read after reset is of index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| maxLen | input | 16 | Buffer capacity in bytes (at least 1) |
| evtThreshold | input | 8 | Event count at which the interrupt rises |
| intClr | input | 1 | Host pulse that clears the interrupt and the event count |
| bdRd | output | 1 | Descriptor read strobe |
| bdWe | output | 1 | Descriptor write strobe |
| bdIdx | output | 13 | Descriptor index for the read or write |
| bdWdata | output | 64 | Descriptor writeback data |
| bdRdata | input | 64 | Descriptor read data, valid the cycle after `bdRd` |
| inValid | input | 1 | Payload byte valid |
| inData | input | 8 | Payload byte |
| inSof | input | 1 | Byte starts a frame |
| inEof | input | 1 | Byte ends a frame |
| inReady | output | 1 | Block accepts a byte this cycle |
| bufWe | output | 1 | Buffer write strobe |
| bufAddr | output | 32 | Buffer byte address |
| bufData | output | 8 | Buffer write byte |
| bufEvent | output | 1 | Per-buffer event pulse |
| irq | output | 1 | Aggregated interrupt |

## Verification
Each result has a fixed timing. Read data is checked one cycle after `bdRd`, and filling begins the cycle after that. A buffer write appears in the same cycle as the accepted byte, and the writeback and `bufEvent` come one cycle after the closing byte. `irq` changes one cycle after the writeback or the clear pulse. The reference model in the bench steps through these cycles on every rising edge, using the same inputs and the memory's read data. Its predictions are compared with the ports at the following falling edge, so each output is checked in exactly the cycle it is due. Scenarios cover a stall on a host-owned descriptor, a wrap back to index 0, continuous reuse and the threshold on the interrupt.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int ST_W     = 16;
  localparam int ST_EMPTY = 15;
  localparam int ST_WRAP  = 13;
  localparam int ST_INT   = 12;
  localparam int ST_LAST  = 11;
  localparam int ST_FIRST = 10;
  localparam int ST_CONT  = 9;

  typedef struct packed {
    logic latchDesc;
    logic takeByte;
    logic writeBack;
  } ringStrobe_t;

  typedef enum logic [1:0] {S_FETCH, S_WAIT, S_FILL, S_WB} ringState_t;
endpackage

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
  import rxring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        descEmpty,
  input  logic        closeHit,
  input  logic        inValid,
  input  logic        inEof,
  output ringStrobe_t stb,
  output logic        bdRd,
  output logic        inReady
);
  ringState_t state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_FETCH;
    else       state <= nxt;
  end

  always_comb begin
    nxt     = state;
    stb     = '0;
    bdRd    = 1'b0;
    inReady = 1'b0;
    case (state)
      S_FETCH: begin
        bdRd = 1'b1;
        nxt  = S_WAIT;
      end
      S_WAIT: begin
        stb.latchDesc = 1'b1;
        nxt = descEmpty ? S_FILL : S_FETCH;
      end
      S_FILL: begin
        inReady = 1'b1;
        if (inValid) begin
          stb.takeByte = 1'b1;
          if (inEof || closeHit) nxt = S_WB;
        end
      end
      S_WB: begin
        stb.writeBack = 1'b1;
        nxt = S_FETCH;
      end
      default: nxt = S_FETCH;
    endcase
  end
endmodule

// File: rtl/rxring_dp.sv
module rxring_dp
  import rxring_pkg::*;
#(
  parameter  int LEN_W  = 16,
  parameter  int PTR_W  = 32,
  parameter  int IDX_W  = 13,
  parameter  int CNT_W  = 8,
  localparam int DESC_W = ST_W + LEN_W + PTR_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobe_t       stb,
  input  logic [DESC_W-1:0] bdRdata,
  input  logic              inSof,
  input  logic              inEof,
  input  logic [LEN_W-1:0]  maxLen,
  input  logic [CNT_W-1:0]  evtThreshold,
  input  logic              intClr,
  output logic              descEmpty,
  output logic              closeHit,
  output logic [IDX_W-1:0]  ringIdx,
  output logic [DESC_W-1:0] bdWdata,
  output logic [PTR_W-1:0]  bufAddr,
  output logic              bufEvent,
  output logic              irq
);
  logic [ST_W-1:0]  descStatus, stOut;
  logic [PTR_W-1:0] descPtr;
  logic [LEN_W-1:0] bufCnt, frameLen, lenOut;
  logic             bufFirst, bufLast;
  logic [CNT_W-1:0] evtCnt, evtNext;
  logic             unusedLenBits;

  assign unusedLenBits = ^bdRdata[ST_W +: LEN_W];
  assign descEmpty = bdRdata[ST_EMPTY];
  assign closeHit  = ({1'b0, bufCnt} + 1'b1) >= {1'b0, maxLen};
  assign bufAddr   = descPtr + PTR_W'(bufCnt);
  assign bufEvent  = stb.writeBack & descStatus[ST_INT];

  always_comb begin
    stOut           = descStatus;
    stOut[ST_EMPTY] = descStatus[ST_CONT];
    stOut[ST_FIRST] = bufFirst;
    stOut[ST_LAST]  = bufLast;
    lenOut          = bufLast ? frameLen : bufCnt;
  end
  assign bdWdata = {descPtr, lenOut, stOut};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descStatus <= '0;
      descPtr    <= '0;
      bufCnt     <= '0;
      frameLen   <= '0;
      bufFirst   <= 1'b0;
      bufLast    <= 1'b0;
      ringIdx    <= '0;
    end else begin
      if (stb.latchDesc) begin
        descStatus <= bdRdata[ST_W-1:0];
        descPtr    <= bdRdata[DESC_W-1 -: PTR_W];
        bufCnt     <= '0;
      end
      if (stb.takeByte) begin
        bufCnt   <= bufCnt + 1'b1;
        frameLen <= inSof ? LEN_W'(1) : frameLen + 1'b1;
        if (bufCnt == '0) bufFirst <= inSof;
        bufLast  <= inEof;
      end
      if (stb.writeBack)
        ringIdx <= descStatus[ST_WRAP] ? '0 : ringIdx + 1'b1;
    end
  end

  assign evtNext = evtCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtCnt <= '0;
      irq    <= 1'b0;
    end else if (intClr) begin
      evtCnt <= '0;
      irq    <= 1'b0;
    end else if (bufEvent) begin
      evtCnt <= evtNext;
      if (evtNext >= evtThreshold) irq <= 1'b1;
    end
  end
endmodule

// File: rtl/rxring_top.sv
module rxring_top
  import rxring_pkg::*;
#(
  parameter  int LEN_W  = 16,
  parameter  int PTR_W  = 32,
  parameter  int IDX_W  = 13,
  parameter  int CNT_W  = 8,
  parameter  int DATA_W = 8,
  localparam int DESC_W = ST_W + LEN_W + PTR_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [LEN_W-1:0]  maxLen,
  input  logic [CNT_W-1:0]  evtThreshold,
  input  logic              intClr,
  output logic              bdRd,
  output logic              bdWe,
  output logic [IDX_W-1:0]  bdIdx,
  output logic [DESC_W-1:0] bdWdata,
  input  logic [DESC_W-1:0] bdRdata,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic              inSof,
  input  logic              inEof,
  output logic              inReady,
  output logic              bufWe,
  output logic [PTR_W-1:0]  bufAddr,
  output logic [DATA_W-1:0] bufData,
  output logic              bufEvent,
  output logic              irq
);
  ringStrobe_t stb;
  logic        descEmpty, closeHit;

  rxring_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .descEmpty(descEmpty), .closeHit(closeHit),
    .inValid(inValid), .inEof(inEof), .stb(stb), .bdRd(bdRd), .inReady(inReady)
  );

  rxring_dp #(.LEN_W(LEN_W), .PTR_W(PTR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .bdRdata(bdRdata), .inSof(inSof), .inEof(inEof),
    .maxLen(maxLen), .evtThreshold(evtThreshold), .intClr(intClr),
    .descEmpty(descEmpty), .closeHit(closeHit), .ringIdx(bdIdx), .bdWdata(bdWdata),
    .bufAddr(bufAddr), .bufEvent(bufEvent), .irq(irq)
  );

  assign bdWe    = stb.writeBack;
  assign bufWe   = stb.takeByte;
  assign bufData = inData;
endmodule

// File: rtl/rxring_chk.sv
module rxring_chk
  import rxring_pkg::*;
#(
  parameter int IDX_W  = 13,
  parameter int DESC_W = 64
)(
  input logic              clk,
  input logic              rstN,
  input logic              intClr,
  input logic              bdRd,
  input logic              bdWe,
  input logic [IDX_W-1:0]  bdIdx,
  input logic [DESC_W-1:0] bdWdata,
  input logic              inValid,
  input logic              inEof,
  input logic              inReady,
  input logic              bufWe,
  input logic              bufEvent,
  input logic              irq
);
  // R1
  no_fill_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    bdRd |=> !inReady);
  // R2
  write_needs_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |-> (inValid && inReady));
  // R3
  eof_then_writeback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inEof) |=> bdWe);
  // R4
  normal_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bdWe && !bdWdata[ST_CONT]) |-> !bdWdata[ST_EMPTY]);
  // R5
  cont_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bdWe && bdWdata[ST_CONT]) |-> bdWdata[ST_EMPTY]);
  // R6
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bdWe && bdWdata[ST_WRAP]) |=> (bdRd && bdIdx == '0));
  // R6
  step_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bdWe && !bdWdata[ST_WRAP]) |=> (bdIdx == IDX_W'($past(bdIdx) + 1'b1)));
  // R8
  event_on_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufEvent |-> (bdWe && bdWdata[ST_INT]));
  // R9
  clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    intClr |=> !irq);
endmodule

bind rxring_top rxring_chk #(.IDX_W(IDX_W), .DESC_W(DESC_W)) chk_i (
  .clk(clk), .rstN(rstN), .intClr(intClr), .bdRd(bdRd), .bdWe(bdWe), .bdIdx(bdIdx),
  .bdWdata(bdWdata), .inValid(inValid), .inEof(inEof), .inReady(inReady),
  .bufWe(bufWe), .bufEvent(bufEvent), .irq(irq)
);

// File: tb/rxring_top_tb.sv
module rxring_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] maxLen = 16'd8;
  logic [7:0]  evtThreshold = 8'd3;
  logic        intClr = 1'b0;
  logic        bdRd, bdWe, inReady, bufWe, bufEvent, irq;
  logic [12:0] bdIdx;
  logic [63:0] bdWdata;
  logic [63:0] bdRdata = '0;
  logic        inValid = 1'b0, inSof = 1'b0, inEof = 1'b0;
  logic [7:0]  inData = '0;
  logic [31:0] bufAddr;
  logic [7:0]  bufData;

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [63:0] mem [4];

  always #2 clk = ~clk;

  rxring_top dut_i (
    .clk(clk), .rstN(rstN), .maxLen(maxLen), .evtThreshold(evtThreshold), .intClr(intClr),
    .bdRd(bdRd), .bdWe(bdWe), .bdIdx(bdIdx), .bdWdata(bdWdata), .bdRdata(bdRdata),
    .inValid(inValid), .inData(inData), .inSof(inSof), .inEof(inEof), .inReady(inReady),
    .bufWe(bufWe), .bufAddr(bufAddr), .bufData(bufData), .bufEvent(bufEvent), .irq(irq)
  );

  // descriptor memory: read data one cycle after the strobe
  always @(posedge clk) begin
    if (bdRd) bdRdata <= mem[bdIdx[1:0]];
    if (bdWe) mem[bdIdx[1:0]] <= bdWdata;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model: phase 0 read, 1 inspect, 2 fill, 3 writeback
  int          mPh, mCnt, mFlen, mEvt, mIdx;
  bit          mFirst, mLast, mIrq;
  logic [63:0] mDesc;

  always @(posedge clk) begin
    if (!rstN) begin
      mPh <= 0; mIdx <= 0; mCnt <= 0; mFlen <= 0; mEvt <= 0;
      mFirst <= 0; mLast <= 0; mIrq <= 0; mDesc <= '0;
    end else begin
      case (mPh)
        0: mPh <= 1;
        1: begin mDesc <= bdRdata; mCnt <= 0; mPh <= bdRdata[15] ? 2 : 0; end
        2: if (inValid) begin
             mCnt  <= mCnt + 1;
             mFlen <= inSof ? 1 : mFlen + 1;
             if (mCnt == 0) mFirst <= inSof;
             mLast <= inEof;
             if (inEof || mCnt + 1 >= int'(maxLen)) mPh <= 3;
           end
        default: begin mPh <= 0; mIdx <= mDesc[13] ? 0 : (mIdx + 1) % 8192; end
      endcase
      if (intClr) begin mEvt <= 0; mIrq <= 0; end
      else if (mPh == 3 && mDesc[12]) begin
        mEvt <= mEvt + 1;
        if (mEvt + 1 >= int'(evtThreshold)) mIrq <= 1;
      end
    end
  end

  function automatic logic [63:0] expWb();
    logic [15:0] s;
    s = (mDesc[15:0] & ~16'h8C00) | (mDesc[9] ? 16'h8000 : 16'h0)
      | (mFirst ? 16'h0400 : 16'h0) | (mLast ? 16'h0800 : 16'h0);
    return {mDesc[63:32], (mLast ? 16'(mFlen) : 16'(mCnt)), s};
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      chk("R1 read strobe", 64'(bdRd), 64'(mPh == 0));
      chk("R6 index", 64'(bdIdx), 64'(mIdx));
      chk("R2 ready", 64'(inReady), 64'(mPh == 2));
      chk("R2 buffer write", 64'(bufWe), 64'(mPh == 2 && inValid));
      if (mPh == 2 && inValid) begin
        chk("R2 buffer address", 64'(bufAddr), 64'(mDesc[63:32] + 32'(mCnt)));
        chk("R2 buffer data", 64'(bufData), 64'(inData));
      end
      chk("R3 writeback strobe", 64'(bdWe), 64'(mPh == 3));
      if (mPh == 3) chk("R7 writeback word", bdWdata, expWb());
      chk("R8 event", 64'(bufEvent), 64'(mPh == 3 && mDesc[12]));
      chk("R9 irq", 64'(irq), 64'(mIrq));
    end
  end

  task automatic sendFrame(input int n, input logic [7:0] tag);
    for (int i = 0; i < n; i++) begin
      inValid = 1'b1; inData = tag + 8'(i); inSof = (i == 0); inEof = (i == n - 1);
      while (!inReady) @(negedge clk);
      @(negedge clk);
    end
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 4; i++)
      mem[i] = {32'(32'h1000 * (i + 1)), 16'h0, (i == 3) ? 16'hB000 : 16'h9000};
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 irq", 64'(irq), 64'h0);
    chk("R10 ready", 64'(inReady), 64'h0);
    chk("R10 bdWe", 64'(bdWe), 64'h0);
    chk("R10 bufWe", 64'(bufWe), 64'h0);
    chk("R10 event", 64'(bufEvent), 64'h0);
    chk("R10 index", 64'(bdIdx), 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    sendFrame(5, 8'h10);
    sendFrame(20, 8'h40);
    repeat (20) @(negedge clk);
    // R1 stall on host-owned descriptor 0 after the wrap
    chk("R1 stall ready", 64'(inReady), 64'h0);
    chk("R6 wrapped index", 64'(bdIdx), 64'h0);
    chk("R9 irq at threshold", 64'(irq), 64'h1);
    chk("R4 desc0 released", mem[0], {32'h1000, 16'd5, 16'h1C00});
    chk("R7 desc2 middle", mem[2], {32'h3000, 16'd8, 16'h1000});
    intClr = 1'b1; @(negedge clk); intClr = 1'b0;
    chk("R9 cleared", 64'(irq), 64'h0);
    mem[0] = {32'h5000, 16'h0, 16'h8200};
    sendFrame(3, 8'h80);
    chk("R5 continuous kept", mem[0], {32'h5000, 16'd3, 16'h8E00});
    repeat (10) @(negedge clk);
    chk("R1 stall at desc1", 64'(inReady), 64'h0);
    mem[1] = {32'h2000, 16'h0, 16'h9000};
    sendFrame(2, 8'h90);
    mem[2] = {32'h3000, 16'h0, 16'h9000};
    mem[3] = {32'h4000, 16'h0, 16'hB000};
    sendFrame(12, 8'hA0);
    sendFrame(4, 8'hC0);
    chk("R7 desc1 single", mem[1], {32'h2000, 16'd2, 16'h1C00});
    chk("R6 desc3 wrap last", mem[3], {32'h4000, 16'd12, 16'h3800});
    chk("R5 desc0 reused", mem[0], {32'h5000, 16'd4, 16'h8E00});
    chk("R9 irq again", 64'(irq), 64'h1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule